// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel

This block is one channel of a DMA engine that walks a chain of transfer descriptors held in memory. Software writes the byte address of the first descriptor into the channel and sets the run bit. The channel reads the six-word descriptor through a word-wide memory read port, loads its working registers, and issues one transfer beat per cycle until the descriptor's byte count is used up. It then follows the descriptor's link word. A link value of `0xFFFF_F800` ends the chain.

The data mover and the peripheral request handshake lie outside the block. Every beat is presented on a beat port as source address, destination address and byte count, and it is accepted in the cycle it is shown. Three single-cycle event pulses report progress: half of a descriptor moved, a descriptor finished, and the whole chain finished. Software can pause and resume the channel and can abort it. The live working registers can be read back through the register window.

The register window of channel `CH_IDX` starts at byte address `0x100 + CH_IDX*0x40`.

Top module: `dma_lli_channel`

## Requirements
- R1: After reset the channel is idle. Every readback register reads 0, and `mem_rd`, `xfer_valid` and all three event outputs are low.
- R2: A write of 1 in bit 0 to the run register (window offset 0x00) while idle fetches the descriptor at the first-descriptor address (offset 0x08). The fetch is six reads at consecutive word addresses, in the order: config, source, destination, byte length, parameter, link. After the fetch, offsets 0x0C, 0x10, 0x14 and 0x1C read back config, source, destination and parameter. Offset 0x00 bit 0 reads 1 while the channel is busy.
- R3: Beat size is set by the source width code in config bits 10:9 (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). The last beat is cut down to the remaining bytes. The source address is held fixed when config bit 5 is 1. When bit 5 is 0, the source address advances by the bytes moved in each beat. The destination follows the same rule with bit 21.
- R4: Offset 0x18 reads the number of bytes of the current descriptor still to be moved.
- R5: `evt_pkg` pulses once per descriptor, in the cycle after its last beat. If the link word is `0xFFFF_F800`, `evt_queue` pulses in the same cycle and the channel goes idle. Otherwise the next descriptor is fetched from the link address.
- R6: `evt_half` pulses exactly once per descriptor of nonzero length. It fires in the cycle after the beat that first brings the remaining count to floor(length/2) or below.
- R7: While the pause bit (offset 0x04, bit 1) is 1, no memory read and no beat is issued, and the remaining count and addresses hold their values. Writing 0 to the pause bit resumes the channel where it stopped.
- R8: A write of 0 in bit 0 to the run register aborts the channel. The channel goes idle and no `evt_pkg` or `evt_queue` pulse follows.
- R9: Register writes outside the channel's own window have no effect, and reads outside it return 0.
- R10: A descriptor of zero length issues no beat, still raises `evt_pkg`, and does not raise `evt_half`.
- R11: A start write while the channel is busy is ignored, and the running chain completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| mem_rd | output | 1 | Descriptor word read request |
| mem_raddr | output | 32 | Descriptor word byte address |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| xfer_valid | output | 1 | Beat issued this cycle |
| xfer_src | output | 32 | Beat source address |
| xfer_dst | output | 32 | Beat destination address |
| xfer_bytes | output | 3 | Bytes in this beat (1 to 4) |
| evt_half | output | 1 | Half-descriptor pulse |
| evt_pkg | output | 1 | Descriptor-done pulse |
| evt_queue | output | 1 | Chain-done pulse |

## Verification
The beat stream is compared one beat at a time against a list the bench computes from each descriptor. The bench drives chains of three descriptors with seeded random widths, fixed or incrementing modes on either side, and lengths that are not multiples of the width, so that faults in the tail-beat trimming and in address stepping show up. Directed cases cover a single word-wide copy with a check of the fetch addresses, a zero-length link inside a chain, a pause in mid-descriptor with a readback of the remaining count, an abort, a second start while busy, and writes to a neighbouring channel's window. Together these separate faults in chain following, event generation, hold behaviour and address decoding from faults in beat arithmetic.

// File: rtl/dmac_pkg.sv
// Shared definitions for the descriptor-chain DMA channel.
// Assumes 32-bit descriptor words and byte addresses.
package dmac_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int IDX_W      = $clog2(DESC_WORDS + 1);
    localparam int BEAT_W     = 3;
    localparam logic [WORD_W-1:0] CHAIN_END = 32'hFFFF_F800;

    // config word fields (destination side is +16)
    localparam int CF_SIO   = 5;
    localparam int CF_SWID  = 9;
    localparam int CF_DSIDE = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_MOVE} ch_state_t;

    // width code to bytes per beat
    function automatic logic [BEAT_W-1:0] width_bytes(input logic [1:0] code);
        case (code)
            2'd0:    width_bytes = 3'd1;
            2'd1:    width_bytes = 3'd2;
            default: width_bytes = 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/dma_ch_regs.sv
// Register window of one channel: decodes the window base, holds the
// pause bit and first-descriptor address, turns run-register writes into
// start/stop pulses and muxes the live engine state onto read data.
// Assumes reads are combinational and writes take effect at the clock edge.
module dma_ch_regs
    import dmac_pkg::*;
#(
    parameter int RADDR_W = 12,
    parameter int CH_IDX  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               busy_i,
    input  logic [WORD_W-1:0]  cfg_i,
    input  logic [WORD_W-1:0]  src_i,
    input  logic [WORD_W-1:0]  dst_i,
    input  logic [WORD_W-1:0]  cnt_i,
    input  logic [WORD_W-1:0]  para_i,
    output logic               start_o,
    output logic               stop_o,
    output logic               pause_o,
    output logic [WORD_W-1:0]  first_o
);
    localparam logic [RADDR_W-1:0] WIN_BASE = RADDR_W'(256 + CH_IDX * 64);

    logic       hit;
    logic [3:0] offs;
    logic       pause_q;
    logic [WORD_W-1:0] first_q;

    assign hit  = reg_addr[RADDR_W-1:6] == WIN_BASE[RADDR_W-1:6];
    assign offs = reg_addr[5:2];

    // run-register writes become one-cycle commands
    always_comb begin
        start_o = reg_we && hit && offs == 4'd0 && reg_wdata[0] && !busy_i;
        stop_o  = reg_we && hit && offs == 4'd0 && !reg_wdata[0];
    end

    // holds pause and first-descriptor address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_q <= 1'b0;
            first_q <= '0;
        end else if (reg_we && hit) begin
            if (offs == 4'd1) pause_q <= reg_wdata[1];
            if (offs == 4'd2) first_q <= reg_wdata;
        end
    end

    assign pause_o = pause_q;
    assign first_o = first_q;

    // readback mux
    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            case (offs)
                4'd0: reg_rdata = {31'b0, busy_i};
                4'd1: reg_rdata = {30'b0, pause_q, 1'b0};
                4'd2: reg_rdata = first_q;
                4'd3: reg_rdata = cfg_i;
                4'd4: reg_rdata = src_i;
                4'd5: reg_rdata = dst_i;
                4'd6: reg_rdata = cnt_i;
                4'd7: reg_rdata = para_i;
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_ch_engine.sv
// Descriptor fetch and beat engine. Reads six descriptor words (one-cycle
// read latency), then issues one beat per cycle while not paused, and
// follows the link word until the end marker.
// Assumes the beat consumer accepts every beat in the cycle it is shown.
module dma_ch_engine
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              pause_i,
    input  logic [WORD_W-1:0] first_i,
    output logic              mem_rd,
    output logic [WORD_W-1:0] mem_raddr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              xfer_valid,
    output logic [WORD_W-1:0] xfer_src,
    output logic [WORD_W-1:0] xfer_dst,
    output logic [BEAT_W-1:0] xfer_bytes,
    output logic              evt_half,
    output logic              evt_pkg,
    output logic              evt_queue,
    output logic              busy_o,
    output logic [WORD_W-1:0] cfg_o,
    output logic [WORD_W-1:0] src_o,
    output logic [WORD_W-1:0] dst_o,
    output logic [WORD_W-1:0] cnt_o,
    output logic [WORD_W-1:0] para_o
);
    ch_state_t         state_q;
    logic [WORD_W-1:0] base_q, cfg_q, src_q, dst_q, cnt_q, len_q, para_q, next_q;
    logic [IDX_W-1:0]  issue_q, cap_idx_q;
    logic              cap_pend_q;

    logic [BEAT_W-1:0] wbytes, beat;
    logic [WORD_W-1:0] new_cnt, half_thr;
    logic              desc_end;

    // beat size, remaining count after beat, end-of-descriptor detection
    always_comb begin
        wbytes     = width_bytes(cfg_q[CF_SWID+1:CF_SWID]);
        beat       = (cnt_q < WORD_W'(wbytes)) ? cnt_q[BEAT_W-1:0] : wbytes;
        new_cnt    = cnt_q - WORD_W'(beat);
        half_thr   = len_q >> 1;
        xfer_valid = state_q == ST_MOVE && !pause_i && cnt_q != '0;
        mem_rd     = state_q == ST_FETCH && !pause_i && issue_q < IDX_W'(DESC_WORDS);
        mem_raddr  = base_q + {{(WORD_W-IDX_W-2){1'b0}}, issue_q, 2'b00};
        desc_end   = (state_q == ST_MOVE && !pause_i && cnt_q == '0) ||
                     (xfer_valid && new_cnt == '0);
    end

    assign xfer_src   = src_q;
    assign xfer_dst   = dst_q;
    assign xfer_bytes = beat;
    assign busy_o     = state_q != ST_IDLE;
    assign cfg_o      = cfg_q;
    assign src_o      = src_q;
    assign dst_o      = dst_q;
    assign cnt_o      = cnt_q;
    assign para_o     = para_q;

    // channel state machine and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            base_q     <= '0;
            cfg_q      <= '0;
            src_q      <= '0;
            dst_q      <= '0;
            cnt_q      <= '0;
            len_q      <= '0;
            para_q     <= '0;
            next_q     <= '0;
            issue_q    <= '0;
            cap_idx_q  <= '0;
            cap_pend_q <= 1'b0;
            evt_half   <= 1'b0;
            evt_pkg    <= 1'b0;
            evt_queue  <= 1'b0;
        end else begin
            evt_half  <= 1'b0;
            evt_pkg   <= 1'b0;
            evt_queue <= 1'b0;
            if (stop_i) begin
                state_q    <= ST_IDLE;
                cap_pend_q <= 1'b0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (start_i) begin
                            state_q <= ST_FETCH;
                            base_q  <= first_i;
                            issue_q <= '0;
                        end
                    end
                    ST_FETCH: begin
                        cap_pend_q <= mem_rd;
                        cap_idx_q  <= issue_q;
                        if (mem_rd) issue_q <= issue_q + 1'b1;
                        if (cap_pend_q) begin
                            case (cap_idx_q)
                                IDX_W'(0): cfg_q  <= mem_rdata;
                                IDX_W'(1): src_q  <= mem_rdata;
                                IDX_W'(2): dst_q  <= mem_rdata;
                                IDX_W'(3): begin
                                    cnt_q <= mem_rdata;
                                    len_q <= mem_rdata;
                                end
                                IDX_W'(4): para_q <= mem_rdata;
                                default:   next_q <= mem_rdata;
                            endcase
                            if (cap_idx_q == IDX_W'(DESC_WORDS - 1)) state_q <= ST_MOVE;
                        end
                    end
                    ST_MOVE: begin
                        if (xfer_valid) begin
                            cnt_q <= new_cnt;
                            if (!cfg_q[CF_SIO]) src_q <= src_q + WORD_W'(beat);
                            if (!cfg_q[CF_SIO+CF_DSIDE]) dst_q <= dst_q + WORD_W'(beat);
                            if (cnt_q > half_thr && new_cnt <= half_thr) evt_half <= 1'b1;
                        end
                        if (desc_end) begin
                            evt_pkg <= 1'b1;
                            if (next_q == CHAIN_END) begin
                                evt_queue <= 1'b1;
                                state_q   <= ST_IDLE;
                            end else begin
                                base_q  <= next_q;
                                issue_q <= '0;
                                state_q <= ST_FETCH;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // consecutive descriptor reads step by one word (R2)
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd) && !$past(stop_i) && $past(state_q) == ST_FETCH)
        |-> mem_raddr == $past(mem_raddr) + 32'd4);

    // a beat never exceeds the bytes left (R3)
    p_beat_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_bytes != '0 && WORD_W'(xfer_bytes) <= cnt_q));

    // remaining count never rises while moving (R4)
    p_cnt_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE && !stop_i) |=> cnt_q <= $past(cnt_q));

    // chain end is always also a descriptor end (R5)
    p_queue_pkg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_queue |-> evt_pkg);

    // paused channel holds its transfer state (R7)
    p_pause_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE && pause_i && !stop_i)
        |=> ($stable(cnt_q) && $stable(src_q) && $stable(dst_q)));

    // abort goes idle with no completion event (R8)
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!busy_o && !evt_pkg && !evt_queue));
endmodule

// File: rtl/dma_lli_channel.sv
// Top of one descriptor-chain DMA channel: register window plus engine.
// Assumes a word-wide descriptor read port with one-cycle latency and a
// beat consumer that is always ready.
module dma_lli_channel
    import dmac_pkg::*;
#(
    parameter int RADDR_W = 12,
    parameter int CH_IDX  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [RADDR_W-1:0] reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               mem_rd,
    output logic [31:0]        mem_raddr,
    input  logic [31:0]        mem_rdata,
    output logic               xfer_valid,
    output logic [31:0]        xfer_src,
    output logic [31:0]        xfer_dst,
    output logic [2:0]         xfer_bytes,
    output logic               evt_half,
    output logic               evt_pkg,
    output logic               evt_queue
);
    logic              start_w, stop_w, pause_w, busy_w;
    logic [WORD_W-1:0] first_w, cfg_w, src_w, dst_w, cnt_w, para_w;

    dma_ch_regs #(.RADDR_W(RADDR_W), .CH_IDX(CH_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy_w),
        .cfg_i(cfg_w), .src_i(src_w), .dst_i(dst_w), .cnt_i(cnt_w),
        .para_i(para_w), .start_o(start_w), .stop_o(stop_w),
        .pause_o(pause_w), .first_o(first_w)
    );

    dma_ch_engine u_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .stop_i(stop_w),
        .pause_i(pause_w), .first_i(first_w), .mem_rd(mem_rd),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .xfer_valid(xfer_valid),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_bytes(xfer_bytes),
        .evt_half(evt_half), .evt_pkg(evt_pkg), .evt_queue(evt_queue),
        .busy_o(busy_w), .cfg_o(cfg_w), .src_o(src_w), .dst_o(dst_w),
        .cnt_o(cnt_w), .para_o(para_w)
    );
endmodule

// File: tb/dma_lli_channel_tb.sv
module dma_lli_channel_tb;
    localparam logic [11:0] A_RUN = 12'h100, A_PAU = 12'h104, A_FIRST = 12'h108,
                            A_CFG = 12'h10C, A_SRC = 12'h110, A_DST = 12'h114,
                            A_CNT = 12'h118, A_PARA = 12'h11C;
    localparam logic [31:0] ENDM = 32'hFFFF_F800;

    logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata, mem_raddr, mem_rdata = '0;
    logic [31:0] xfer_src, xfer_dst;
    logic [2:0]  xfer_bytes;
    logic mem_rd, xfer_valid, evt_half, evt_pkg, evt_queue;

    always #10 clk = ~clk;

    dma_lli_channel u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .xfer_valid(xfer_valid),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .xfer_bytes(xfer_bytes),
        .evt_half(evt_half), .evt_pkg(evt_pkg), .evt_queue(evt_queue)
    );

    logic [31:0] mem [0:255];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_raddr[9:2]];

    int checks = 0, errors = 0;
    logic [31:0] exp_src [0:511];
    logic [31:0] exp_dst [0:511];
    logic [2:0]  exp_b   [0:511];
    int exp_n = 0, exp_half = 0, beats = 0, pkgs = 0, halves = 0, queues = 0, rds = 0;
    logic [31:0] rd_log [0:63];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // beat, event and fetch monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_valid) begin
                if (beats < exp_n) begin
                    chk(xfer_src == exp_src[beats], "R3 beat src", xfer_src, exp_src[beats]);
                    chk(xfer_dst == exp_dst[beats], "R3 beat dst", xfer_dst, exp_dst[beats]);
                    chk(xfer_bytes == exp_b[beats], "R3 beat size", 32'(xfer_bytes), 32'(exp_b[beats]));
                end else chk(1'b0, "R3 extra beat", 32'(beats), 32'(exp_n));
                beats++;
            end
            if (evt_pkg) pkgs++;
            if (evt_half) halves++;
            if (evt_queue) queues++;
            if (mem_rd) begin
                if (rds < 64) rd_log[rds] = mem_raddr;
                rds++;
            end
        end
    end

    task automatic clear_mon();
        exp_n = 0; exp_half = 0; beats = 0; pkgs = 0; halves = 0; queues = 0; rds = 0;
    endtask

    function automatic logic [31:0] mk_cfg(input int sw, input bit sio, input int dw, input bit dio, input int line);
        mk_cfg = 32'(line & 31) | (32'(sio) << 5) | (32'(sw & 3) << 9) |
                 ((32'(1) | (32'(dio) << 5) | (32'(dw & 3) << 9)) << 16);
    endfunction

    // store descriptor and append its expected beats
    task automatic put_desc(input int slot, input logic [31:0] cfg, src, dst, len, next);
        int w; logic [31:0] s, d, rem; int b;
        int base = 64 + slot * 8;
        mem[base] = cfg; mem[base+1] = src; mem[base+2] = dst;
        mem[base+3] = len; mem[base+4] = 32'h8; mem[base+5] = next;
        w = (cfg[10:9] == 2'd0) ? 1 : (cfg[10:9] == 2'd1) ? 2 : 4;
        s = src; d = dst; rem = len;
        if (len != 0) exp_half++;
        while (rem != 0) begin
            b = (rem < 32'(w)) ? int'(rem) : w;
            exp_src[exp_n] = s; exp_dst[exp_n] = d; exp_b[exp_n] = 3'(b);
            exp_n++;
            if (!cfg[5]) s = s + 32'(b);
            if (!cfg[21]) d = d + 32'(b);
            rem = rem - 32'(b);
        end
    endtask

    function automatic logic [31:0] slot_addr(input int slot);
        slot_addr = 32'h100 + 32'(slot * 32);
    endfunction

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v; int n = 0;
        do begin reg_read(A_RUN, v); n++; end while (v[0] && n < 3000);
        chk(!v[0], tag, v, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, c0, sb; int b0, r0, seed;
        seed = int'($urandom(32'd20240517));
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk(!xfer_valid && !mem_rd && !evt_pkg && !evt_half && !evt_queue, "R1 outputs idle", 32'(xfer_valid), 0);
        for (int a = 0; a < 8; a++) begin
            reg_read(12'h100 + 12'(a * 4), v);
            chk(v == 0, "R1 readback zero", v, 0);
        end

        // R2/R3/R4/R5 single word-wide copy, len 10 -> 4,4,2
        clear_mon();
        put_desc(0, mk_cfg(2, 0, 2, 0, 1), 32'h1000, 32'h2000, 32'd10, ENDM);
        reg_write(A_FIRST, slot_addr(0));
        reg_write(A_RUN, 32'h1);
        reg_read(A_RUN, v);
        chk(v[0], "R2 busy after start", v, 1);
        wait_idle("R5 chain end goes idle");
        chk(rds == 6, "R2 six fetch reads", 32'(rds), 6);
        for (int k = 0; k < 6; k++)
            chk(rd_log[k] == slot_addr(0) + 32'(4 * k), "R2 fetch address order", rd_log[k], slot_addr(0) + 32'(4 * k));
        reg_read(A_CFG, v);  chk(v == mk_cfg(2, 0, 2, 0, 1), "R2 cfg readback", v, mk_cfg(2, 0, 2, 0, 1));
        reg_read(A_PARA, v); chk(v == 32'h8, "R2 param readback", v, 32'h8);
        reg_read(A_SRC, v);  chk(v == 32'h100A, "R3 src advanced", v, 32'h100A);
        reg_read(A_CNT, v);  chk(v == 0, "R4 count zero at end", v, 0);
        chk(beats == 3, "R3 beat count", 32'(beats), 3);
        chk(pkgs == 1 && queues == 1, "R5 pkg and queue pulses", 32'(pkgs), 1);
        chk(halves == 1, "R6 half pulse once", 32'(halves), 1);

        // random chains: R3, R5, R6
        for (int round = 0; round < 6; round++) begin
            clear_mon();
            for (int s = 0; s < 3; s++)
                put_desc(s + 1, mk_cfg(int'($urandom % 3), 1'($urandom), int'($urandom % 3), 1'($urandom), int'($urandom % 31)),
                         $urandom, $urandom, 32'(1 + $urandom % 40), (s == 2) ? ENDM : slot_addr(s + 2));
            reg_write(A_FIRST, slot_addr(1));
            reg_write(A_RUN, 32'h1);
            wait_idle("R5 random chain finishes");
            chk(beats == exp_n, "R3 random beat total", 32'(beats), 32'(exp_n));
            chk(pkgs == 3, "R5 pkg per descriptor", 32'(pkgs), 3);
            chk(queues == 1, "R5 one queue pulse", 32'(queues), 1);
            chk(halves == exp_half, "R6 half per descriptor", 32'(halves), 32'(exp_half));
        end

        // R10 zero-length descriptor inside a chain
        clear_mon();
        put_desc(5, mk_cfg(0, 0, 0, 0, 1), 32'h40, 32'h80, 32'd0, slot_addr(6));
        put_desc(6, mk_cfg(1, 0, 1, 0, 1), 32'h400, 32'h800, 32'd4, ENDM);
        reg_write(A_FIRST, slot_addr(5));
        reg_write(A_RUN, 32'h1);
        wait_idle("R10 zero-length chain finishes");
        chk(beats == 2, "R10 only second descriptor beats", 32'(beats), 2);
        chk(pkgs == 2, "R10 pkg for zero length", 32'(pkgs), 2);
        chk(halves == 1, "R10 no half for zero length", 32'(halves), 1);

        // R7 pause mid-descriptor, R4 remaining count
        clear_mon();
        put_desc(7, mk_cfg(0, 0, 0, 1, 1), 32'h3000, 32'h5000, 32'd20, ENDM);
        reg_write(A_FIRST, slot_addr(7));
        reg_write(A_RUN, 32'h1);
        repeat (10) @(negedge clk);
        reg_write(A_PAU, 32'h2);
        repeat (2) @(negedge clk);
        reg_read(A_CNT, c0);
        b0 = beats; r0 = rds;
        chk(b0 > 0 && b0 < 20, "R7 paused mid-descriptor", 32'(b0), 32'd10);
        chk(c0 == 32'(20 - b0), "R4 remaining count", c0, 32'(20 - b0));
        reg_read(A_SRC, sb);
        chk(sb == 32'h3000 + 32'(b0), "R4 source at pause", sb, 32'h3000 + 32'(b0));
        repeat (12) @(negedge clk);
        reg_read(A_CNT, v);
        chk(v == c0, "R7 count held", v, c0);
        chk(beats == b0 && rds == r0, "R7 no beats while paused", 32'(beats), 32'(b0));
        reg_read(A_DST, v);
        chk(v == 32'h5000, "R3 fixed destination", v, 32'h5000);
        reg_write(A_PAU, 32'h0);
        wait_idle("R7 resumes to end");
        chk(beats == 20 && pkgs == 1, "R7 all beats after resume", 32'(beats), 20);

        // R8 abort
        clear_mon();
        put_desc(8, mk_cfg(0, 0, 0, 0, 1), 32'h6000, 32'h7000, 32'd40, ENDM);
        reg_write(A_FIRST, slot_addr(8));
        reg_write(A_RUN, 32'h1);
        repeat (12) @(negedge clk);
        reg_write(A_RUN, 32'h0);
        reg_read(A_RUN, v);
        chk(!v[0], "R8 idle after stop", v, 0);
        b0 = beats;
        repeat (30) @(negedge clk);
        chk(beats == b0, "R8 no beats after stop", 32'(beats), 32'(b0));
        chk(pkgs == 0 && queues == 0, "R8 no completion events", 32'(pkgs + queues), 0);

        // R9 neighbouring window
        clear_mon();
        reg_write(A_FIRST, slot_addr(0));
        reg_write(12'h148, 32'hDEAD_BEEF);
        reg_read(A_FIRST, v);
        chk(v == slot_addr(0), "R9 foreign write ignored", v, slot_addr(0));
        reg_read(12'h148, v);
        chk(v == 0, "R9 foreign read zero", v, 0);
        reg_write(12'h140, 32'h1);
        repeat (10) @(negedge clk);
        reg_read(A_RUN, v);
        chk(!v[0] && beats == 0 && rds == 0, "R9 foreign start ignored", v, 0);

        // R11 start while busy
        clear_mon();
        put_desc(9, mk_cfg(0, 0, 0, 0, 1), 32'h9000, 32'hA000, 32'd16, ENDM);
        reg_write(A_FIRST, slot_addr(9));
        reg_write(A_RUN, 32'h1);
        repeat (4) @(negedge clk);
        reg_write(A_FIRST, slot_addr(0));
        reg_write(A_RUN, 32'h1);
        wait_idle("R11 original chain ends");
        repeat (10) @(negedge clk);
        chk(beats == 16 && pkgs == 1, "R11 restart ignored", 32'(beats), 16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule